// File: doc/BRIEF.md
# Byte-Mapped Digital I/O Register File

This block is a small register file of sixteen byte-wide locations on a plain synchronous bus. The bus has an address, a write strobe, write data and a combinational read-data return. Three byte latches drive 24 output lines. Twenty-four input-only lines pass through a two-flop synchronizer and can be read back. One further byte-wide port is bidirectional. A bit in a control byte sets its direction, and its output latch can be loaded before the port is switched to output mode.

The change-of-state logic lives in a neighbouring block. This block only passes traffic to and from it. It returns that block's four status bytes and its enable byte on reads. Writes to those locations become one-hot strobes that carry the bus write data. A write to the top location starts a one-cycle soft-reset pulse, which clears every local register and is also sent to the neighbour. A read of the same location returns the level of the interrupt pin.

Top module: `dio_regfile`

## Requirements
- R1: After reset, the 24 output lines, the bidirectional port's output data and its output enable are all 0, and reads of locations 0 to 3 and 12 return 0.
- R2: A write to location 0, 1 or 2 loads output lines 0-7, 8-15 or 16-23 from the write data on that clock edge. A read of the same location returns that byte, and the other two bytes are unchanged.
- R3: Reads of locations 4, 5 and 6 return input lines 0-7, 8-15 and 16-23 through a two-flop synchronizer. A change on the inputs appears in the read data after exactly two rising clock edges, not one.
- R4: Writes to locations 4, 5, 6, 7 and 13 change no output line, no latch and no control bit. A read of location 13 returns 0.
- R5: Location 3 is the bidirectional port's output latch, and it drives the port's output data in either direction. Bit 1 of control location 12 drives the port's output enable (1 means output). Location 12 reads back as it was written. The latch takes writes while bit 1 is 0.
- R6: A read of location 7 returns the bidirectional port's pin levels after the same two-flop synchronizer.
- R7: A read of location 8+k (k = 0..3) returns status byte k of the neighbour. A write to 8+k raises bit k of the clear strobe in that same cycle only, with the write data on the shared data output. The strobe is never more than one-hot.
- R8: A read of location 14 returns the neighbour's enable byte. A write to 14 raises the enable write strobe in that same cycle and no clear strobe.
- R9: A read of location 15 returns the interrupt pin level in bit 0, with bits 7..1 at 0.
- R10: A write to location 15 raises the soft-reset output for exactly the one cycle after the write edge. At the end of that cycle, all output latches, the bidirectional latch and the control byte become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register location |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| out_lines | output | 24 | Latched output lines |
| in_lines | input | 24 | Asynchronous input lines |
| bidir_pin_in | input | 8 | Pin levels of the bidirectional port |
| bidir_pin_out | output | 8 | Output data of the bidirectional port |
| bidir_oe | output | 1 | Output enable of the bidirectional port |
| cos_status | input | 32 | Four change-of-state status bytes from the neighbour |
| cos_enable | input | 8 | Change-of-state enable byte from the neighbour |
| cos_clr_we | output | 4 | One-hot status clear strobes |
| cos_en_we | output | 1 | Enable-byte write strobe |
| cos_wdata | output | 8 | Data for the neighbour's writes |
| irq_level | input | 1 | Interrupt pin level |
| soft_rst_pulse | output | 1 | One-cycle soft-reset pulse |

## Verification
The assertions assume the bus is driven synchronously. Address, strobe and data must be stable around each rising edge, and a write lasts exactly one cycle. The input-timing property also assumes that reset has been released for at least two edges before synchronized data is compared. The stimulus changes every bus and pin input only on falling edges and applies each write as a single-cycle strobe. It waits for the synchronizer depth before it reads back new pin values. It also keeps back-to-back writes off the soft-reset cycle, so the priority of the clear is the only behaviour that cycle exercises.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int BYTE_W = 8;

  // Select byte idx from a vector zero-extended to 64 bits.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [63:0] vec, input int idx);
    return vec[idx*BYTE_W +: BYTE_W];
  endfunction

  // True when location a falls in [lo, lo+n).
  function automatic logic in_window(input int a, input int lo, input int n);
    return (a >= lo) && (a < lo + n);
  endfunction
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/dio_latch_bank.sv
module dio_latch_bank #(
  parameter int BANKS = 4,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [BANKS-1:0]   we,
  input  logic [W-1:0]       wdata,
  output logic [BANKS*W-1:0] q
);
  logic [W-1:0] bank_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bank_q[b] <= '0;
      else if (clr)   bank_q[b] <= '0;
      else if (we[b]) bank_q[b] <= wdata;
    end
    assign q[b*W +: W] = bank_q[b];
  end
endmodule

// File: rtl/dio_read_mux.sv
module dio_read_mux import dio_pkg::*; #(
  parameter int OUT_BANKS = 3,
  parameter int AW        = 4,
  localparam int LAT_W     = (OUT_BANKS+1)*BYTE_W,
  localparam int COS_BANKS = OUT_BANKS+1,
  localparam int OFF_IN0   = OUT_BANKS+1,
  localparam int OFF_COS0  = 2*OUT_BANKS+2,
  localparam int OFF_CTL   = OFF_COS0+COS_BANKS,
  localparam int OFF_EN    = OFF_CTL+2,
  localparam int OFF_RST   = OFF_CTL+3
) (
  input  logic [AW-1:0]               addr,
  input  logic [LAT_W-1:0]            lat_all,
  input  logic [LAT_W-1:0]            samp_all,
  input  logic [COS_BANKS*BYTE_W-1:0] cos_status,
  input  logic [BYTE_W-1:0]           ctl_q,
  input  logic [BYTE_W-1:0]           cos_enable,
  input  logic                        irq_level,
  output logic [BYTE_W-1:0]           rdata
);
  int a;

  always_comb begin
    a     = int'(addr);
    rdata = '0;
    if (in_window(a, 0, OUT_BANKS+1))
      rdata = pick_byte(64'(lat_all), a);
    else if (in_window(a, OFF_IN0, OUT_BANKS+1))
      rdata = pick_byte(64'(samp_all), a - OFF_IN0);
    else if (in_window(a, OFF_COS0, COS_BANKS))
      rdata = pick_byte(64'(cos_status), a - OFF_COS0);
    else if (a == OFF_CTL)
      rdata = ctl_q;
    else if (a == OFF_EN)
      rdata = cos_enable;
    else if (a == OFF_RST)
      rdata = {{(BYTE_W-1){1'b0}}, irq_level};
  end
endmodule

// File: rtl/dio_regfile.sv
module dio_regfile import dio_pkg::*; #(
  parameter int OUT_BANKS  = 3,
  parameter int SYNC_DEPTH = 2,
  parameter int DIR_BIT    = 1,
  localparam int BW          = BYTE_W,
  localparam int COS_BANKS   = OUT_BANKS+1,
  localparam int OFF_BLATCH  = OUT_BANKS,
  localparam int OFF_IN0     = OUT_BANKS+1,
  localparam int OFF_COS0    = 2*OUT_BANKS+2,
  localparam int OFF_CTL     = OFF_COS0+COS_BANKS,
  localparam int OFF_RSVD    = OFF_CTL+1,
  localparam int OFF_EN      = OFF_CTL+2,
  localparam int OFF_RST     = OFF_CTL+3,
  localparam int NREG        = OFF_RST+1,
  localparam int AW          = $clog2(NREG),
  localparam int OUT_W       = OUT_BANKS*BW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         bus_addr,
  input  logic                  bus_wr,
  input  logic [BW-1:0]         bus_wdata,
  output logic [BW-1:0]         bus_rdata,
  output logic [OUT_W-1:0]      out_lines,
  input  logic [OUT_W-1:0]      in_lines,
  input  logic [BW-1:0]         bidir_pin_in,
  output logic [BW-1:0]         bidir_pin_out,
  output logic                  bidir_oe,
  input  logic [COS_BANKS*BW-1:0] cos_status,
  input  logic [BW-1:0]         cos_enable,
  output logic [COS_BANKS-1:0]  cos_clr_we,
  output logic                  cos_en_we,
  output logic [BW-1:0]         cos_wdata,
  input  logic                  irq_level,
  output logic                  soft_rst_pulse
);
  // Named internal events, visible to the bound checker.
  logic [NREG-1:0]           wr_hit;
  logic                      soft_req;
  logic                      wr_ignored;
  logic                      dir_out;
  logic [BW-1:0]             ctl_q;
  logic [(OUT_BANKS+1)*BW-1:0] lat_all;
  logic [(OUT_BANKS+1)*BW-1:0] samp_all;

  always_comb begin
    wr_hit = '0;
    if (bus_wr) wr_hit[bus_addr] = 1'b1;
  end

  assign soft_req   = wr_hit[OFF_RST];
  assign wr_ignored = (|wr_hit[OFF_IN0 +: OUT_BANKS+1]) | wr_hit[OFF_RSVD];
  assign cos_clr_we = wr_hit[OFF_COS0 +: COS_BANKS];
  assign cos_en_we  = wr_hit[OFF_EN];
  assign cos_wdata  = bus_wdata;

  // Soft reset: one cycle, never re-armed from inside its own cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_rst_pulse <= 1'b0;
    else        soft_rst_pulse <= soft_req & ~soft_rst_pulse;
  end

  // Output latches plus the bidirectional latch.
  dio_latch_bank #(.BANKS(OUT_BANKS+1), .W(BW)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_rst_pulse),
    .we    (wr_hit[OFF_BLATCH:0]),
    .wdata (bus_wdata),
    .q     (lat_all)
  );

  assign out_lines     = lat_all[OUT_W-1:0];
  assign bidir_pin_out = lat_all[OUT_W +: BW];

  // Control byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ctl_q <= '0;
    else if (soft_rst_pulse)  ctl_q <= '0;
    else if (wr_hit[OFF_CTL]) ctl_q <= bus_wdata;
  end

  assign dir_out  = ctl_q[DIR_BIT];
  assign bidir_oe = dir_out;

  // Input and bidirectional pins share one synchronizer.
  dio_sync #(.W((OUT_BANKS+1)*BW), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bidir_pin_in, in_lines}),
    .q     (samp_all)
  );

  dio_read_mux #(.OUT_BANKS(OUT_BANKS), .AW(AW)) u_rd (
    .addr       (bus_addr),
    .lat_all    (lat_all),
    .samp_all   (samp_all),
    .cos_status (cos_status),
    .ctl_q      (ctl_q),
    .cos_enable (cos_enable),
    .irq_level  (irq_level),
    .rdata      (bus_rdata)
  );
endmodule

// File: rtl/dio_regfile_chk.sv
module dio_regfile_chk #(
  parameter int AW        = 4,
  parameter int BW        = 8,
  parameter int OUT_W     = 24,
  parameter int COS_BANKS = 4,
  parameter int OFF_IN0   = 4,
  parameter int OFF_CTL   = 12,
  parameter int DIR_BIT   = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [AW-1:0]        bus_addr,
  input logic                 bus_wr,
  input logic [BW-1:0]        bus_wdata,
  input logic [BW-1:0]        bus_rdata,
  input logic [OUT_W-1:0]     out_lines,
  input logic [BW-1:0]        in_lo,
  input logic                 bidir_oe,
  input logic [BW-1:0]        bidir_pin_out,
  input logic [COS_BANKS-1:0] cos_clr_we,
  input logic                 soft_req,
  input logic                 wr_ignored,
  input logic                 soft_rst_pulse
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> !soft_rst_pulse);
  a_r10_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    soft_req && !soft_rst_pulse |=> soft_rst_pulse);
  a_r10_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> (out_lines == '0) && !bidir_oe && (bidir_pin_out == '0));
  a_r2_low_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr == '0) && !soft_rst_pulse |=> out_lines[BW-1:0] == $past(bus_wdata));
  a_r4_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored && !soft_rst_pulse |=> $stable(out_lines) && $stable(bidir_oe) && $stable(bidir_pin_out));
  a_r7_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cos_clr_we));
  a_r7_clr_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|cos_clr_we) |-> bus_wr);
  a_r5_oe_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(OFF_CTL)) |-> bus_rdata[DIR_BIT] == bidir_oe);
  a_r3_two_flop_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2) && (bus_addr == AW'(OFF_IN0)) |-> bus_rdata == $past(in_lo, 2));
endmodule

bind dio_regfile dio_regfile_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_addr       (bus_addr),
  .bus_wr         (bus_wr),
  .bus_wdata      (bus_wdata),
  .bus_rdata      (bus_rdata),
  .out_lines      (out_lines),
  .in_lo          (in_lines[7:0]),
  .bidir_oe       (bidir_oe),
  .bidir_pin_out  (bidir_pin_out),
  .cos_clr_we     (cos_clr_we),
  .soft_req       (soft_req),
  .wr_ignored     (wr_ignored),
  .soft_rst_pulse (soft_rst_pulse)
);

// File: tb/tb_dio_regfile.sv
module tb_dio_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] out_lines;
  logic [23:0] in_lines = '0;
  logic [7:0]  bidir_pin_in = '0;
  logic [7:0]  bidir_pin_out;
  logic        bidir_oe;
  logic [31:0] cos_status = '0;
  logic [7:0]  cos_enable = '0;
  logic [3:0]  cos_clr_we;
  logic        cos_en_we;
  logic [7:0]  cos_wdata;
  logic        irq_level = 1'b0;
  logic        soft_rst_pulse;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] exp_q [$];
  logic [3:0] adr_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dio_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_lines(out_lines),
    .in_lines(in_lines), .bidir_pin_in(bidir_pin_in), .bidir_pin_out(bidir_pin_out),
    .bidir_oe(bidir_oe), .cos_status(cos_status), .cos_enable(cos_enable),
    .cos_clr_we(cos_clr_we), .cos_en_we(cos_en_we), .cos_wdata(cos_wdata),
    .irq_level(irq_level), .soft_rst_pulse(soft_rst_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one read per cycle, expected value pushed to the scoreboard.
  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    bus_wr   = 1'b0;
    bus_addr = a;
    exp_q.push_back(exp);
    adr_q.push_back(a);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  // Monitor: compares read data away from the rising edge.
  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      logic [3:0] a;
      string t;
      e = exp_q.pop_front();
      a = adr_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s read@%0d actual=%h expected=%h", t, a, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 out_lines", 32'(out_lines), 32'h0);
    chk("R1 bidir_oe", 32'(bidir_oe), 32'h0);
    chk("R1 bidir_pin_out", 32'(bidir_pin_out), 32'h0);
    rd(4'd0, 8'h00, "R1");
    rd(4'd3, 8'h00, "R1");
    rd(4'd12, 8'h00, "R1");

    // R2 output latches
    wr(4'd0, 8'hA5);
    wr(4'd1, 8'h3C);
    wr(4'd2, 8'h81);
    chk("R2 out_lines", 32'(out_lines), 32'h0081_3CA5);
    rd(4'd0, 8'hA5, "R2");
    rd(4'd1, 8'h3C, "R2");
    rd(4'd2, 8'h81, "R2");
    wr(4'd1, 8'h00);
    chk("R2 single byte", 32'(out_lines), 32'h0081_00A5);

    // R5 bidirectional latch written in input mode, then output mode
    wr(4'd3, 8'h5A);
    chk("R5 oe in input mode", 32'(bidir_oe), 32'h0);
    chk("R5 latch drives data", 32'(bidir_pin_out), 32'h5A);
    rd(4'd3, 8'h5A, "R5");
    wr(4'd12, 8'h02);
    chk("R5 oe in output mode", 32'(bidir_oe), 32'h1);
    chk("R5 latch kept", 32'(bidir_pin_out), 32'h5A);
    rd(4'd12, 8'h02, "R5");

    // R3 synchronizer depth
    in_lines = 24'hC3_96_0F;
    rd(4'd4, 8'h00, "R3 zero edges");
    rd(4'd4, 8'h00, "R3 one edge");
    rd(4'd4, 8'h0F, "R3 two edges");
    rd(4'd5, 8'h96, "R3");
    rd(4'd6, 8'hC3, "R3");

    // R6 bidirectional pins
    bidir_pin_in = 8'hE7;
    @(negedge clk);
    @(negedge clk);
    rd(4'd7, 8'hE7, "R6");

    // R4 ignored writes and reserved location
    wr(4'd4, 8'hFF);
    wr(4'd5, 8'hFF);
    wr(4'd6, 8'hFF);
    wr(4'd7, 8'hFF);
    wr(4'd13, 8'hFF);
    chk("R4 out_lines", 32'(out_lines), 32'h0081_00A5);
    chk("R4 bidir_pin_out", 32'(bidir_pin_out), 32'h5A);
    chk("R4 bidir_oe", 32'(bidir_oe), 32'h1);
    rd(4'd13, 8'h00, "R4");
    rd(4'd4, 8'h0F, "R4");
    rd(4'd12, 8'h02, "R4");

    // R7 status pass-through and clear strobes
    cos_status = 32'h44_33_22_11;
    rd(4'd8, 8'h11, "R7");
    rd(4'd9, 8'h22, "R7");
    rd(4'd10, 8'h33, "R7");
    rd(4'd11, 8'h44, "R7");
    bus_addr = 4'd10; bus_wdata = 8'h9C; bus_wr = 1'b1;
    #1;
    chk("R7 clr strobe", 32'(cos_clr_we), 32'h4);
    chk("R7 clr data", 32'(cos_wdata), 32'h9C);
    chk("R7 no en strobe", 32'(cos_en_we), 32'h0);
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    chk("R7 strobe one cycle", 32'(cos_clr_we), 32'h0);
    @(negedge clk);

    // R8 enable pass-through
    cos_enable = 8'h6B;
    rd(4'd14, 8'h6B, "R8");
    bus_addr = 4'd14; bus_wdata = 8'h11; bus_wr = 1'b1;
    #1;
    chk("R8 en strobe", 32'(cos_en_we), 32'h1);
    chk("R8 no clr strobe", 32'(cos_clr_we), 32'h0);
    @(negedge clk);
    bus_wr = 1'b0;

    // R9 interrupt level
    irq_level = 1'b1;
    rd(4'd15, 8'h01, "R9");
    irq_level = 1'b0;
    rd(4'd15, 8'h00, "R9");

    // R10 soft reset
    chk("R10 idle", 32'(soft_rst_pulse), 32'h0);
    wr(4'd15, 8'h00);
    chk("R10 pulse high", 32'(soft_rst_pulse), 32'h1);
    @(negedge clk);
    chk("R10 pulse single", 32'(soft_rst_pulse), 32'h0);
    chk("R10 out_lines cleared", 32'(out_lines), 32'h0);
    chk("R10 oe cleared", 32'(bidir_oe), 32'h0);
    chk("R10 bidir cleared", 32'(bidir_pin_out), 32'h0);
    rd(4'd12, 8'h00, "R10");
    rd(4'd3, 8'h00, "R10");
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule